// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps coherence state for one private cache that shares a single bus with other caches. Each line of a small direct-mapped tag array carries one of four states: Modified (dirty, only copy), Exclusive (clean, only copy), Shared (clean, other copies may exist) and Invalid. The block answers processor accesses and issues the bus transactions that keep the line states consistent with every other cache. It also watches the bus traffic of other masters and downgrades or gives up its own copies in response.

The processor side is a valid/ready stream. The processor raises `cpu_valid` and holds `cpu_write` and `cpu_addr` steady until `cpu_ready` is high at a clock edge. `cpu_ready` is high for exactly that one cycle. The processor applies back-pressure only by not issuing a request. The block can stall the processor for as long as it needs, because bus work and snoops come first. An address is a line address `{tag, index}`, with the index in the low `IDX_W` bits.

On the bus, the block raises `bus_req` and waits for `bus_gnt`. It then drives one command cycle and samples the other caches' replies (`bus_shared_in`, `bus_hitm_in`) in the cycle after that. It keeps `bus_req` high through both cycles and drops it afterwards. A transaction from another master arrives as a one-cycle `snp_valid` pulse. The block answers it on `snp_shared_out` or `snp_hitm_out` in the following cycle. `snp_valid` is never raised while this block holds the bus.

Top module: `mesi_snoop_ctl`

## Requirements
- R1: After reset every line is Invalid and `bus_req`, `bus_cmd_valid`, `snp_shared_out`, `snp_hitm_out` and `cpu_ready` are low.
- R2: A read whose tag matches a valid line completes in the same cycle it is presented, with no bus command and no state change.
- R3: A read miss issues READ (code 0) for `cpu_addr`. The line is installed Shared if `bus_shared_in` or `bus_hitm_in` is high in the reply cycle, and Exclusive otherwise.
- R4: A write to an Invalid line or a different tag issues RWITM (code 1). A reply without `bus_hitm_in` installs the line Modified and completes the write.
- R5: An RWITM reply with `bus_hitm_in` high does not complete the write. `bus_req` is low in the next cycle, and RWITM for the same address is issued again later.
- R6: A write hit on Shared issues INVAL (code 2) and then completes with the line Modified. A write hit on Exclusive or Modified completes in one cycle with no bus command and leaves the line Modified.
- R7: A snooped READ (code 0) to a held line answers one cycle later. Exclusive and Shared raise `snp_shared_out` and end Shared. Modified raises `snp_hitm_out` and ends Shared. A line that is not held gives no answer.
- R8: A snooped RWITM takes Shared or Exclusive to Invalid with no answer. On a Modified line it raises `snp_hitm_out`, then requests the bus, issues WBACK (code 3) for that address and ends Invalid.
- R9: A snooped INVAL (code 2) makes a held copy Invalid.
- R10: A miss whose index holds a Modified line with another tag first issues WBACK for `{old tag, index}`, and only then issues the READ or RWITM for the new address.
- R11: A processor request presented in a cycle with `snp_valid` high does not complete in that cycle. The snoop's state change applies before the request is evaluated.
- R12: `bus_cmd_valid` is high for exactly one cycle. That cycle follows a cycle with `bus_req` and `bus_gnt` both high, and nothing is issued while the grant is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | IDX_W+TAG_W | Line address {tag, index} |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd_valid | output | 1 | Command cycle on the bus |
| bus_cmd | output | 2 | 0 READ, 1 RWITM, 2 INVAL, 3 WBACK |
| bus_addr | output | IDX_W+TAG_W | Command line address |
| bus_shared_in | input | 1 | Another cache keeps a clean copy (reply cycle) |
| bus_hitm_in | input | 1 | Another cache owns the line dirty (reply cycle) |
| snp_valid | input | 1 | Another master's command is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | IDX_W+TAG_W | Snooped line address |
| snp_shared_out | output | 1 | Clean-copy answer, one cycle after snoop |
| snp_hitm_out | output | 1 | Dirty-owner answer, one cycle after snoop |

## Verification
The bind checker watches the bus handshake on every cycle: commands last one cycle and only follow a grant, the two snoop answers never overlap and only follow a snoop, the processor never completes during a snoop, and the bus is released after a dirty-owner reply. Most line-state transitions can only be seen through ordered scenarios. Examples are Exclusive becoming Modified on a silent write, a Modified owner writing back after a snooped RWITM, eviction ordering, and the RWITM retry. The bench drives these scenarios and infers each state from the next command or snoop answer.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [1:0] {BC_READ = 2'd0, BC_RWITM = 2'd1, BC_INVAL = 2'd2, BC_WBACK = 2'd3} bcmd_t;
  typedef enum logic [1:0] {MS_IDLE, MS_ARB, MS_CMD, MS_RSP} mst_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store import mesi_pkg::*; #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output mesi_t            ra_st,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output mesi_t            rb_st,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  mesi_t            w_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  mesi_t            st_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        st_q[g]  <= ST_I;
      end else if (we && w_idx == IDX_W'(g)) begin
        tag_q[g] <= w_tag;
        st_q[g]  <= w_st;
      end
    end
  end

  assign ra_tag = tag_q[ra_idx];
  assign ra_st  = st_q[ra_idx];
  assign rb_tag = tag_q[rb_idx];
  assign rb_st  = st_q[rb_idx];
endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop import mesi_pkg::*; #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   snp_valid,
  input  logic [1:0]             snp_cmd,
  input  logic [IDX_W+TAG_W-1:0] snp_addr,
  input  logic [TAG_W-1:0]       look_tag,
  input  mesi_t                  look_st,
  input  logic                   wb_clear,
  output logic                   we,
  output mesi_t                  w_st,
  output logic                   shared_out,
  output logic                   hitm_out,
  output logic                   wb_pend,
  output logic [IDX_W+TAG_W-1:0] wb_addr
);
  localparam int ADDR_W = IDX_W + TAG_W;

  logic  held, sh_d, hm_d, set_wb;
  bcmd_t cmd;

  assign cmd  = bcmd_t'(snp_cmd);
  assign held = (look_st != ST_I) && (look_tag == snp_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    we = 1'b0; w_st = look_st; sh_d = 1'b0; hm_d = 1'b0; set_wb = 1'b0;
    if (snp_valid && held) begin
      unique case (cmd)
        BC_READ: begin
          we = 1'b1; w_st = ST_S;
          if (look_st == ST_M) hm_d = 1'b1;
          else                 sh_d = 1'b1;
        end
        BC_RWITM: begin
          if (look_st == ST_M) begin
            hm_d = 1'b1; set_wb = 1'b1;       // owner keeps M until its write-back
          end else begin
            we = 1'b1; w_st = ST_I;
          end
        end
        BC_INVAL: begin
          we = 1'b1; w_st = ST_I;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shared_out <= 1'b0;
      hitm_out   <= 1'b0;
      wb_pend    <= 1'b0;
      wb_addr    <= '0;
    end else begin
      shared_out <= sh_d;
      hitm_out   <= hm_d;
      if (set_wb) begin
        wb_pend <= 1'b1;
        wb_addr <= snp_addr;
      end else if (wb_clear) begin
        wb_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mesi_master.sv
module mesi_master import mesi_pkg::*; #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_valid,
  input  logic                   cpu_write,
  input  logic [IDX_W+TAG_W-1:0] cpu_addr,
  output logic                   cpu_ready,
  input  logic [TAG_W-1:0]       look_tag,
  input  mesi_t                  look_st,
  input  logic                   snp_stall,
  input  logic                   wb_pend,
  input  logic [IDX_W+TAG_W-1:0] wb_addr,
  output logic                   wb_clear,
  output logic                   bus_req,
  input  logic                   bus_gnt,
  output logic                   bus_cmd_valid,
  output bcmd_t                  bus_cmd,
  output logic [IDX_W+TAG_W-1:0] bus_addr,
  input  logic                   bus_shared_in,
  input  logic                   bus_hitm_in,
  output logic                   we,
  output logic [IDX_W-1:0]       w_idx,
  output logic [TAG_W-1:0]       w_tag,
  output mesi_t                  w_st
);
  localparam int ADDR_W = IDX_W + TAG_W;

  mst_t  state, nxt;
  bcmd_t op;
  logic [TAG_W-1:0] cpu_tag;
  logic [IDX_W-1:0] cpu_idx;
  logic tag_eq, hit;

  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign tag_eq  = (look_tag == cpu_tag);
  assign hit     = tag_eq && (look_st != ST_I);

  always_comb begin
    nxt = state; cpu_ready = 1'b0; bus_req = 1'b0; bus_cmd_valid = 1'b0;
    bus_cmd = BC_READ; bus_addr = '0; wb_clear = 1'b0;
    we = 1'b0; w_idx = cpu_idx; w_tag = cpu_tag; w_st = ST_I;
    unique case (state)
      MS_IDLE: begin
        if (wb_pend) begin
          nxt = MS_ARB;
        end else if (cpu_valid && !snp_stall) begin
          if (hit && !cpu_write) begin
            cpu_ready = 1'b1;
          end else if (hit && look_st != ST_S) begin
            cpu_ready = 1'b1; we = 1'b1; w_st = ST_M;
          end else begin
            nxt = MS_ARB;
          end
        end
      end
      MS_ARB: begin
        bus_req = 1'b1;
        if (bus_gnt) nxt = MS_CMD;
      end
      MS_CMD: begin
        bus_req = 1'b1; bus_cmd_valid = 1'b1; nxt = MS_RSP;
        if (wb_pend) begin
          bus_cmd = BC_WBACK; bus_addr = wb_addr; wb_clear = 1'b1;
          we = 1'b1; w_idx = wb_addr[IDX_W-1:0]; w_tag = wb_addr[ADDR_W-1:IDX_W]; w_st = ST_I;
        end else if (look_st == ST_M && !tag_eq) begin
          bus_cmd = BC_WBACK; bus_addr = {look_tag, cpu_idx};
          we = 1'b1; w_tag = look_tag; w_st = ST_I;
        end else begin
          bus_addr = cpu_addr;
          if (cpu_write && hit) bus_cmd = BC_INVAL;
          else if (cpu_write)   bus_cmd = BC_RWITM;
          else                  bus_cmd = BC_READ;
        end
      end
      MS_RSP: begin
        bus_req = 1'b1; nxt = MS_IDLE;
        unique case (op)
          BC_READ: begin
            we = 1'b1; cpu_ready = 1'b1;
            w_st = (bus_shared_in || bus_hitm_in) ? ST_S : ST_E;
          end
          BC_RWITM: begin
            if (!bus_hitm_in) begin
              we = 1'b1; cpu_ready = 1'b1; w_st = ST_M;
            end
          end
          BC_INVAL: begin
            we = 1'b1; cpu_ready = 1'b1; w_st = ST_M;
          end
          default: ;
        endcase
      end
      default: nxt = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= MS_IDLE;
      op    <= BC_READ;
    end else begin
      state <= nxt;
      if (state == MS_CMD) op <= bus_cmd;
    end
  end
endmodule

// File: rtl/mesi_snoop_ctl.sv
module mesi_snoop_ctl import mesi_pkg::*; #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_valid,
  input  logic                   cpu_write,
  input  logic [IDX_W+TAG_W-1:0] cpu_addr,
  output logic                   cpu_ready,
  output logic                   bus_req,
  input  logic                   bus_gnt,
  output logic                   bus_cmd_valid,
  output logic [1:0]             bus_cmd,
  output logic [IDX_W+TAG_W-1:0] bus_addr,
  input  logic                   bus_shared_in,
  input  logic                   bus_hitm_in,
  input  logic                   snp_valid,
  input  logic [1:0]             snp_cmd,
  input  logic [IDX_W+TAG_W-1:0] snp_addr,
  output logic                   snp_shared_out,
  output logic                   snp_hitm_out
);
  localparam int ADDR_W = IDX_W + TAG_W;

  logic [TAG_W-1:0] a_tag, b_tag, m_tag, w_tag;
  mesi_t            a_st, b_st, s_wst, m_wst, w_st;
  logic [IDX_W-1:0] m_idx, w_idx;
  logic             s_we, m_we, wb_pend, wb_clear;
  logic [ADDR_W-1:0] wb_addr;
  bcmd_t            cmd_e;

  // Snoop writes win the single write port; the master never writes during a snoop.
  assign w_idx = s_we ? snp_addr[IDX_W-1:0] : m_idx;
  assign w_tag = s_we ? b_tag : m_tag;
  assign w_st  = s_we ? s_wst : m_wst;
  assign bus_cmd = cmd_e;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(cpu_addr[IDX_W-1:0]), .ra_tag(a_tag), .ra_st(a_st),
    .rb_idx(snp_addr[IDX_W-1:0]), .rb_tag(b_tag), .rb_st(b_st),
    .we(s_we | m_we), .w_idx(w_idx), .w_tag(w_tag), .w_st(w_st)
  );

  mesi_snoop #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .look_tag(b_tag), .look_st(b_st), .wb_clear(wb_clear),
    .we(s_we), .w_st(s_wst),
    .shared_out(snp_shared_out), .hitm_out(snp_hitm_out),
    .wb_pend(wb_pend), .wb_addr(wb_addr)
  );

  mesi_master #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_master (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
    .look_tag(a_tag), .look_st(a_st), .snp_stall(snp_valid),
    .wb_pend(wb_pend), .wb_addr(wb_addr), .wb_clear(wb_clear),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd(cmd_e), .bus_addr(bus_addr),
    .bus_shared_in(bus_shared_in), .bus_hitm_in(bus_hitm_in),
    .we(m_we), .w_idx(m_idx), .w_tag(m_tag), .w_st(m_wst)
  );
endmodule

// File: rtl/mesi_ctl_chk.sv
module mesi_ctl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_cmd_valid,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_hitm_in,
  input logic              snp_valid,
  input logic              snp_shared_out,
  input logic              snp_hitm_out
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!bus_req && !snp_shared_out && !snp_hitm_out));

  p_cmd_after_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |-> (bus_req && $past(bus_req && bus_gnt)));

  p_cmd_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |=> !bus_cmd_valid);

  p_answer_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_shared_out && snp_hitm_out));

  p_answer_follows_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_shared_out || snp_hitm_out) |-> $past(snp_valid));

  p_snoop_stalls_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready);

  p_retry_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_cmd_valid && bus_cmd == 2'd1) && bus_hitm_in) |-> (!cpu_ready ##1 !bus_req));

  p_addr_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cmd_valid |-> (bus_addr == '0));
endmodule

bind mesi_snoop_ctl mesi_ctl_chk #(.ADDR_W(IDX_W + TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .bus_hitm_in(bus_hitm_in), .snp_valid(snp_valid),
  .snp_shared_out(snp_shared_out), .snp_hitm_out(snp_hitm_out)
);

// File: tb/sim_mesi_snoop_ctl.sv
`timescale 1ns/1ps
module sim_mesi_snoop_ctl;
  localparam int IDX_W = 2, TAG_W = 4, AW = IDX_W + TAG_W;
  localparam logic [1:0] C_RD = 2'd0, C_RWITM = 2'd1, C_INV = 2'd2, C_WB = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0, cpu_ready;
  logic [AW-1:0] cpu_addr = '0;
  logic bus_req, bus_cmd_valid;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic bus_shared_in = 1'b0, bus_hitm_in = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared_out, snp_hitm_out;
  logic hold_gnt = 1'b0, bus_gnt;

  int n_chk = 0, n_bad = 0, cmd_count = 0;
  bit finished = 1'b0, cmd_seen = 1'b0, plan_shared = 1'b0, hitm_once = 1'b0;
  logic [1:0] seen_cmd = '0;
  logic [AW+1:0] exp_q[$];
  string exp_tag[$];

  always #4 clk = ~clk;
  assign bus_gnt = bus_req && !hold_gnt;

  mesi_snoop_ctl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u0 (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [1:0] c, input logic [AW-1:0] a, input string req);
    exp_q.push_back({c, a});
    exp_tag.push_back(req);
  endtask

  // Monitor: scoreboard of bus commands
  always @(negedge clk) begin
    cmd_seen = bus_cmd_valid;
    seen_cmd = bus_cmd;
    if (rst_n && bus_cmd_valid) begin
      cmd_count++;
      if (exp_q.size() == 0) begin
        chk("R12", "unexpected bus command", int'({bus_cmd, bus_addr}), -1);
      end else begin
        logic [AW+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(t, "bus command {cmd,addr}", int'({bus_cmd, bus_addr}), int'(e));
      end
    end
  end

  // Other caches' replies, in the cycle after each command
  always @(posedge clk) begin
    #1;
    bus_shared_in = cmd_seen && plan_shared;
    bus_hitm_in   = 1'b0;
    if (cmd_seen && seen_cmd == C_RWITM && hitm_once) begin
      bus_hitm_in = 1'b1;
      hitm_once   = 1'b0;
    end
  end

  task automatic cpu_op(input bit wr, input logic [AW-1:0] a, output int cyc, output int ncmd);
    int c0;
    @(posedge clk); #1;
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cyc = 0; c0 = cmd_count;
    forever begin
      @(negedge clk);
      cyc++;
      if (cpu_ready || cyc > 200) break;
    end
    @(posedge clk); #1;
    cpu_valid = 1'b0;
    ncmd = cmd_count - c0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input int esh,
                       input int ehm, input string req);
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(posedge clk); #1;
    snp_valid = 1'b0;
    @(negedge clk);
    chk(req, "snoop shared answer", int'(snp_shared_out), esh);
    chk(req, "snoop hitm answer", int'(snp_hitm_out), ehm);
  endtask

  task automatic settle(input string req);
    repeat (8) @(negedge clk);
    chk(req, "scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    int cyc, nc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "bus_req", int'(bus_req), 0);
    chk("R1", "cmd_valid", int'(bus_cmd_valid), 0);
    chk("R1", "snoop answers", int'(snp_shared_out | snp_hitm_out), 0);
    chk("R1", "cpu_ready", int'(cpu_ready), 0);
    snoop(C_RD, 6'h04, 0, 0, "R1");

    // R3 read miss, no sharer -> Exclusive
    expect_cmd(C_RD, 6'h04, "R3");
    cpu_op(1'b0, 6'h04, cyc, nc);
    chk("R3", "read miss commands", nc, 1);
    // R6 write hit on Exclusive is silent
    cpu_op(1'b1, 6'h04, cyc, nc);
    chk("R6", "E write cycles", cyc, 1);
    chk("R6", "E write commands", nc, 0);
    // R7 Modified answers hitm and drops to Shared
    snoop(C_RD, 6'h04, 0, 1, "R7");
    snoop(C_RD, 6'h04, 1, 0, "R7");
    // R2 read hit
    cpu_op(1'b0, 6'h04, cyc, nc);
    chk("R2", "read hit cycles", cyc, 1);
    chk("R2", "read hit commands", nc, 0);
    snoop(C_RD, 6'h04, 1, 0, "R2");
    // R6 write hit on Shared -> INVAL then M
    expect_cmd(C_INV, 6'h04, "R6");
    cpu_op(1'b1, 6'h04, cyc, nc);
    chk("R6", "S write commands", nc, 1);
    cpu_op(1'b1, 6'h04, cyc, nc);
    chk("R6", "M write cycles", cyc, 1);
    // R8 snooped RWITM on Modified -> hitm, write-back, Invalid
    expect_cmd(C_WB, 6'h04, "R8");
    snoop(C_RWITM, 6'h04, 0, 1, "R8");
    settle("R8");
    snoop(C_RD, 6'h04, 0, 0, "R8");

    // R3 sharer present -> Shared; R8 RWITM on Shared -> Invalid
    plan_shared = 1'b1;
    expect_cmd(C_RD, 6'h09, "R3");
    cpu_op(1'b0, 6'h09, cyc, nc);
    plan_shared = 1'b0;
    snoop(C_RD, 6'h09, 1, 0, "R3");
    snoop(C_RWITM, 6'h09, 0, 0, "R8");
    snoop(C_RD, 6'h09, 0, 0, "R8");
    // R9 INVAL on Exclusive copy
    expect_cmd(C_RD, 6'h09, "R9");
    cpu_op(1'b0, 6'h09, cyc, nc);
    snoop(C_INV, 6'h09, 0, 0, "R9");
    snoop(C_RD, 6'h09, 0, 0, "R9");
    // R8 RWITM on Exclusive -> Invalid
    expect_cmd(C_RD, 6'h09, "R8");
    cpu_op(1'b0, 6'h09, cyc, nc);
    snoop(C_RWITM, 6'h09, 0, 0, "R8");
    snoop(C_RD, 6'h09, 0, 0, "R8");

    // R4 write miss -> RWITM -> Modified
    expect_cmd(C_RWITM, 6'h0E, "R4");
    cpu_op(1'b1, 6'h0E, cyc, nc);
    chk("R4", "write miss commands", nc, 1);
    cpu_op(1'b1, 6'h0E, cyc, nc);
    chk("R4", "follow-up write cycles", cyc, 1);
    // R10 eviction of Modified before new read
    expect_cmd(C_WB, 6'h0E, "R10");
    expect_cmd(C_RD, 6'h16, "R10");
    cpu_op(1'b0, 6'h16, cyc, nc);
    chk("R10", "eviction commands", nc, 2);
    snoop(C_RD, 6'h0E, 0, 0, "R10");
    snoop(C_RD, 6'h16, 1, 0, "R10");

    // R5 RWITM retry after dirty-owner reply
    hitm_once = 1'b1;
    expect_cmd(C_RWITM, 6'h1B, "R5");
    expect_cmd(C_RWITM, 6'h1B, "R5");
    cpu_op(1'b1, 6'h1B, cyc, nc);
    chk("R5", "retry commands", nc, 2);
    snoop(C_RD, 6'h1B, 0, 1, "R5");

    // R11 snoop priority over a same-cycle write
    expect_cmd(C_RD, 6'h04, "R11");
    cpu_op(1'b0, 6'h04, cyc, nc);
    expect_cmd(C_INV, 6'h04, "R11");
    @(posedge clk); #1;
    cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 6'h04;
    snp_valid = 1'b1; snp_cmd = C_RD; snp_addr = 6'h04;
    @(negedge clk);
    chk("R11", "ready during snoop", int'(cpu_ready), 0);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    @(negedge clk);
    chk("R11", "snoop answered first", int'(snp_shared_out), 1);
    cyc = 0;
    while (!cpu_ready && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    @(posedge clk); #1;
    cpu_valid = 1'b0;
    settle("R11");

    // R12 nothing issued while grant withheld
    hold_gnt = 1'b1;
    expect_cmd(C_RD, 6'h1D, "R12");
    fork
      cpu_op(1'b0, 6'h1D, cyc, nc);
      begin
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          chk("R12", "req held", int'(bus_req), 1);
          chk("R12", "no cmd without grant", int'(bus_cmd_valid), 0);
        end
        hold_gnt = 1'b0;
      end
    join
    chk("R12", "granted read commands", nc, 1);
    settle("R12");
    report();
  end
endmodule